// File: doc/BRIEF.md
# Selectable Reference Divider with Phase-Frequency Detector

This block sits in the digital part of a frequency-synthesizer loop. It divides the crystal reference clock (nominally 4 MHz, usable from 3.15 to 4.05 MHz) by one of three ratios, 640, 512 or 1024, and emits one reference-clock-wide pulse per divided period. That pulse goes to a phase-frequency detector, which compares it against a feedback pulse from the programmable loop divider. The detector drives a tri-state charge-pump control made of up (source), down (sink) and enable signals.

A three-bit test selector can take the pump control away from the detector and hold it in high impedance, in a constant sink or in a constant source. A separate pump-current select bit is passed straight through to the analog pump, which chooses between its normal 280 uA current and its 60 uA test current. The analog pump, loop amplifier and prescaler are outside this block. The whole block runs in the reference clock domain, and the feedback pulse is taken as a one-cycle pulse synchronous to that clock.

Top module: `refpfd_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pump_up`, `pump_dn`, `pump_en` and `ref_tick` are 0, and the divide ratio is 640.
- R2: `ratio_sel[0]`=0 selects divide by 640 whatever `ratio_sel[1]` is; `ratio_sel`=2'b11 selects 512; `ratio_sel`=2'b01 selects 1024. The time between successive `ref_tick` pulses equals the selected ratio in clock cycles.
- R3: `ref_tick` is high for exactly one clock cycle per divided period.
- R4: A new `ratio_sel` value takes effect only at the next terminal count: the period in progress completes at the old ratio.
- R5: In detect mode, a `ref_tick` with no pending feedback raises `pump_up` on the next cycle; it stays high until `fb_pulse` arrives. `pump_dn` then rises for one cycle of overlap, and the cycle after that both are low.
- R6: In detect mode, a `fb_pulse` with no pending reference raises `pump_dn` on the next cycle; on the next `ref_tick` `pump_up` joins it for one cycle, and the cycle after that both are low.
- R7: In detect mode, `pump_en` is high exactly when `pump_up` or `pump_dn` is high, so an idle detector leaves the pump in high impedance.
- R8: `test_sel[2]`=0 gives detect mode whatever `test_sel[1:0]` holds; `test_sel`=3'b100 is also detect mode.
- R9: `test_sel`=3'b101 forces `pump_up`=0, `pump_dn`=0 and `pump_en`=0.
- R10: `test_sel`=3'b110 forces a constant sink (`pump_dn`=1, `pump_en`=1, `pump_up`=0); `test_sel`=3'b111 forces a constant source (`pump_up`=1, `pump_en`=1, `pump_dn`=0).
- R11: `pump_hi_cur` equals `cp_sel` (1 = normal 280 uA, 0 = 60 uA test current).
- R12: A `ref_tick` and a `fb_pulse` in the same cycle raise `pump_up` and `pump_dn` together for one cycle, after which both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Crystal reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_pulse | input | 1 | One-cycle pulse from the loop divider |
| ratio_sel | input | 2 | Reference ratio select (bit 1, bit 0) |
| test_sel | input | 3 | Pump test selector (bit 2 enables forcing) |
| cp_sel | input | 1 | Pump current select |
| pump_up | output | 1 | Pump source request |
| pump_dn | output | 1 | Pump sink request |
| pump_en | output | 1 | Pump drive enable (0 = high impedance) |
| pump_hi_cur | output | 1 | Pump current select to the analog pump |
| ref_tick | output | 1 | Divided reference pulse and monitor |

## Verification
The bench changes the ratio halfway through a period. A design that applies the new ratio at once gives one short or long period, where 640 is expected. It also checks the don't-care bit of the 640 code and the 3'b100 test code, either of which a careless decoder maps to the wrong ratio or to a forced state. The detector is driven with reference first, feedback first and both in the same cycle. A design that clears its flags before the overlap cycle, or that leaves one flag set when both edges coincide, fails the cycle-exact checks of up, down and enable.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;

    typedef enum logic [1:0] {
        RATIO_640  = 2'd0,
        RATIO_512  = 2'd1,
        RATIO_1024 = 2'd2
    } ref_ratio_e;

    typedef enum logic [1:0] {
        PUMP_DETECT = 2'd0,
        PUMP_HIZ    = 2'd1,
        PUMP_SINK   = 2'd2,
        PUMP_SOURCE = 2'd3
    } pump_force_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic en;
    } pump_drive_t;

    // bit 0 clear always means the default ratio
    function automatic ref_ratio_e decode_ratio(input logic [1:0] sel);
        if (!sel[0])
            return RATIO_640;
        else if (sel[1])
            return RATIO_512;
        else
            return RATIO_1024;
    endfunction

    function automatic pump_force_e decode_force(input logic [2:0] sel);
        case (sel)
            3'b101:  return PUMP_HIZ;
            3'b110:  return PUMP_SINK;
            3'b111:  return PUMP_SOURCE;
            default: return PUMP_DETECT;
        endcase
    endfunction

endpackage

// File: rtl/refpfd_divider.sv
module refpfd_divider
    import refpfd_pkg::*;
#(
    parameter int DIV_A = 640,
    parameter int DIV_B = 512,
    parameter int DIV_C = 1024,
    parameter int CNT_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio_sel,
    output logic       tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_q;
    logic [CNT_W-1:0] term_next;

    always_comb begin
        case (decode_ratio(ratio_sel))
            RATIO_512:  term_next = CNT_W'(DIV_B - 1);
            RATIO_1024: term_next = CNT_W'(DIV_C - 1);
            default:    term_next = CNT_W'(DIV_A - 1);
        endcase
    end

    assign tick = (cnt_q == term_q);

    // the terminal value is only reloaded on wrap, so a period never shortens
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            term_q <= CNT_W'(DIV_A - 1);
        end else if (tick) begin
            cnt_q  <= '0;
            term_q <= term_next;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/refpfd_detector.sv
module refpfd_detector (
    input  logic clk,
    input  logic rst,
    input  logic ref_evt,
    input  logic fb_evt,
    output logic up,
    output logic dn
);

    logic up_q;
    logic dn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (up_q && dn_q) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_q | ref_evt;
            dn_q <= dn_q | fb_evt;
        end
    end

    assign up = up_q;
    assign dn = dn_q;

endmodule

// File: rtl/refpfd_pump_ctrl.sv
module refpfd_pump_ctrl
    import refpfd_pkg::*;
(
    input  logic [2:0] test_sel,
    input  logic       det_up,
    input  logic       det_dn,
    output logic       up,
    output logic       dn,
    output logic       en
);

    pump_drive_t drv;

    always_comb begin
        case (decode_force(test_sel))
            PUMP_HIZ:    drv = '{up: 1'b0, dn: 1'b0, en: 1'b0};
            PUMP_SINK:   drv = '{up: 1'b0, dn: 1'b1, en: 1'b1};
            PUMP_SOURCE: drv = '{up: 1'b1, dn: 1'b0, en: 1'b1};
            default:     drv = '{up: det_up, dn: det_dn, en: det_up | det_dn};
        endcase
    end

    assign up = drv.up;
    assign dn = drv.dn;
    assign en = drv.en;

endmodule

// File: rtl/refpfd_top.sv
module refpfd_top #(
    parameter int DIV_A = 640,
    parameter int DIV_B = 512,
    parameter int DIV_C = 1024
) (
    input  logic       clk_ref,
    input  logic       rst,
    input  logic       fb_pulse,
    input  logic [1:0] ratio_sel,
    input  logic [2:0] test_sel,
    input  logic       cp_sel,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_en,
    output logic       pump_hi_cur,
    output logic       ref_tick
);

    localparam int DIV_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int DIV_MAX = (DIV_AB > DIV_C) ? DIV_AB : DIV_C;
    localparam int CNT_W   = $clog2(DIV_MAX);

    logic det_up;
    logic det_dn;

    refpfd_divider #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B),
        .DIV_C (DIV_C),
        .CNT_W (CNT_W)
    ) u_div (
        .clk       (clk_ref),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .tick      (ref_tick)
    );

    refpfd_detector u_det (
        .clk     (clk_ref),
        .rst     (rst),
        .ref_evt (ref_tick),
        .fb_evt  (fb_pulse),
        .up      (det_up),
        .dn      (det_dn)
    );

    refpfd_pump_ctrl u_pump (
        .test_sel (test_sel),
        .det_up   (det_up),
        .det_dn   (det_dn),
        .up       (pump_up),
        .dn       (pump_dn),
        .en       (pump_en)
    );

    assign pump_hi_cur = cp_sel;

endmodule

// File: rtl/refpfd_chk.sv
module refpfd_chk (
    input logic       clk_ref,
    input logic       rst,
    input logic [2:0] test_sel,
    input logic       cp_sel,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       pump_en,
    input logic       pump_hi_cur,
    input logic       ref_tick
);

    // R3
    tick_width_chk: assert property (@(posedge clk_ref) disable iff (rst)
        ref_tick |=> !ref_tick);

    // R5
    overlap_clear_chk: assert property (@(posedge clk_ref) disable iff (rst)
        (pump_up && pump_dn) |=> !(pump_up && pump_dn));

    // R7
    detect_enable_chk: assert property (@(posedge clk_ref) disable iff (rst)
        (test_sel[2] == 1'b0) |-> (pump_en == (pump_up || pump_dn)));

    // R9
    force_hiz_chk: assert property (@(posedge clk_ref) disable iff (rst)
        (test_sel == 3'b101) |-> (!pump_en && !pump_up && !pump_dn));

    // R10
    force_sink_chk: assert property (@(posedge clk_ref) disable iff (rst)
        (test_sel == 3'b110) |-> (pump_en && pump_dn && !pump_up));

    // R10
    force_source_chk: assert property (@(posedge clk_ref) disable iff (rst)
        (test_sel == 3'b111) |-> (pump_en && pump_up && !pump_dn));

    // R11
    cur_sel_chk: assert property (@(posedge clk_ref) disable iff (rst)
        pump_hi_cur == cp_sel);

endmodule

bind refpfd_top refpfd_chk u_chk (
    .clk_ref     (clk_ref),
    .rst         (rst),
    .test_sel    (test_sel),
    .cp_sel      (cp_sel),
    .pump_up     (pump_up),
    .pump_dn     (pump_dn),
    .pump_en     (pump_en),
    .pump_hi_cur (pump_hi_cur),
    .ref_tick    (ref_tick)
);

// File: tb/refpfd_top_tb.sv
`timescale 1ns/1ps
module refpfd_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       fb_pulse;
    logic [1:0] ratio_sel;
    logic [2:0] test_sel;
    logic       cp_sel;
    logic       pump_up, pump_dn, pump_en, pump_hi_cur, ref_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    refpfd_top u_dut (
        .clk_ref     (clk),
        .rst         (rst),
        .fb_pulse    (fb_pulse),
        .ratio_sel   (ratio_sel),
        .test_sel    (test_sel),
        .cp_sel      (cp_sel),
        .pump_up     (pump_up),
        .pump_dn     (pump_dn),
        .pump_en     (pump_en),
        .pump_hi_cur (pump_hi_cur),
        .ref_tick    (ref_tick)
    );

    // [7:5] test_sel, [4] cp_sel, [3] up, [2] dn, [1] en, [0] hi_cur
    localparam logic [7:0] VEC [8] = '{
        8'b0001_0001, 8'b0110_0000, 8'b0101_0001, 8'b1001_0001,
        8'b1011_0001, 8'b1100_0110, 8'b1111_1011, 8'b1110_1010
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // returns the number of falling edges until ref_tick is seen high
    task automatic wait_tick(output int waited);
        waited = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            waited++;
            if (ref_tick) return;
        end
        check("R3 tick missing", 0, 1);
    endtask

    function automatic int drv3();
        return {pump_up, pump_dn, pump_en};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int w;
        int w2;
        rst = 1'b1; fb_pulse = 1'b0; ratio_sel = 2'b00; test_sel = 3'b000; cp_sel = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 drive in reset", drv3(), 0);
        check("R1 tick in reset", int'(ref_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 drive after reset", drv3(), 0);

        // static mode table, detector idle
        foreach (VEC[i]) begin
            string req;
            test_sel = VEC[i][7:5];
            cp_sel   = VEC[i][4];
            #1;
            if (VEC[i][7:5] == 3'b101)      req = "R9";
            else if (VEC[i][7:6] == 2'b11)  req = "R10";
            else                            req = "R8";
            check(req, drv3(), int'(VEC[i][3:1]));
            check("R11", int'(pump_hi_cur), int'(VEC[i][0]));
        end
        test_sel = 3'b000; cp_sel = 1'b1;

        // R5 reference leads
        wait_tick(w);
        @(negedge clk);
        check("R3 tick one cycle", int'(ref_tick), 0);
        check("R5 up after ref", drv3(), 3'b101);
        repeat (5) @(negedge clk);
        check("R5 up held", drv3(), 3'b101);
        fb_pulse = 1'b1;
        @(negedge clk); fb_pulse = 1'b0;
        check("R5 overlap", drv3(), 3'b111);
        @(negedge clk);
        check("R5 R7 cleared idle", drv3(), 3'b000);

        // R6 feedback leads
        repeat (10) @(negedge clk);
        fb_pulse = 1'b1;
        @(negedge clk); fb_pulse = 1'b0;
        check("R6 dn after fb", drv3(), 3'b011);
        wait_tick(w);
        @(negedge clk);
        check("R6 overlap", drv3(), 3'b111);
        @(negedge clk);
        check("R6 cleared", drv3(), 3'b000);

        // R12 coincident edges
        wait_tick(w);
        fb_pulse = 1'b1;
        @(negedge clk); fb_pulse = 1'b0;
        check("R12 both", drv3(), 3'b111);
        @(negedge clk);
        check("R12 cleared", drv3(), 3'b000);

        // R2 default and don't-care bit
        wait_tick(w);
        wait_tick(w);
        check("R2 ratio 640", w, 640);
        ratio_sel = 2'b10;
        wait_tick(w);
        wait_tick(w);
        check("R2 ratio 640 with sel 10", w, 640);

        // R4 mid-period change
        repeat (100) @(negedge clk);
        ratio_sel = 2'b11;
        wait_tick(w);
        check("R4 period in progress", w + 100, 640);
        wait_tick(w2);
        check("R2 ratio 512", w2, 512);

        ratio_sel = 2'b01;
        wait_tick(w);
        check("R2 ratio 1024", w, 1024);
        @(negedge clk);
        check("R3 tick width at 1024", int'(ref_tick), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule